// File: doc/BRIEF.md
# Nibble/Dibit Elastic Frame Bridge

This block joins a 4-bit media-independent interface (MII) to a 2-bit reduced media-independent interface (RMII) when the two sides run from independent clocks. The MII side has a fast clock. One nibble moves there on each cycle that carries a slow tick enable. The RMII side moves one dibit on every cycle of its own clock. The two clocks have no phase relation and may drift apart by a few hundred ppm. No signal is sampled directly across the boundary. Each direction writes its frame into its own small asynchronous FIFO. The FIFO pointers cross the boundary as Gray code through two flip-flop synchronizers, and each side computes its full, empty and fill flags locally.

Every FIFO entry holds one nibble and a frame flag. A frame is stored as its data entries followed by one end marker, which has the flag cleared. The read side of each direction is a pacer that moves one nibble per slot. It holds back a new frame until the FIFO holds at least half its depth. After every frame it keeps the output idle for a minimum number of nibble slots. Clock drift is absorbed in this idle time only. The gap is longer when the FIFO fills slowly and stays at its minimum when data is already waiting. Frame data is never added or removed.

Each writer is a state machine. W_IDLE moves to W_FRAME on the first nibble of a frame, or to W_DROP if the FIFO is full at that moment. W_FRAME moves to W_DROP when a nibble meets a full FIFO. At the end of the frame it writes the end marker and returns to W_IDLE, or it moves to W_CLOSE if the FIFO is full. W_DROP discards nibbles until the frame ends and then moves to W_CLOSE. W_CLOSE writes the end marker as soon as there is space and returns to W_IDLE. Each pacer is a state machine. P_WAIT moves to P_SEND when the fill level reaches the threshold. P_SEND moves to P_GAP when it pops an end marker. P_GAP moves back to P_WAIT when the minimum gap has elapsed.

Top module: `nib_pair_bridge`

## Requirements
- R1: After reset, both frame outputs are low, the nibble and dibit outputs are zero, and both drop flags are clear.
- R2: On the RMII output, each nibble is sent as two dibits on consecutive clocks, bits [1:0] first and then bits [3:2]. The frame output stays high for an even number of clocks.
- R3: On the RMII input, consecutive dibits that arrive while the frame input is high are paired into nibbles, with the first dibit becoming bits [1:0]. The MII output nibble and frame signal change only at edges where the tick is high.
- R4: When no overflow occurs, each input frame comes out as exactly one frame, with every nibble present once and in its original order.
- R5: An output frame starts only when the FIFO holds at least half its depth (8 entries with AW=4).
- R6: Between two output frames there are at least GAP_NIB idle nibble slots. On the RMII side this is at least 2*GAP_NIB clocks.
- R7: The FIFO is never written while full and never read while empty.
- R8: A nibble that finds the FIFO full sets a sticky drop flag. The rest of that frame is discarded, only a leading part of it is delivered, and the next frame passes intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_clk | input | 1 | MII-side clock |
| m_rst | input | 1 | MII-side synchronous reset, active high |
| m_tick | input | 1 | Nibble-slot enable in the m_clk domain |
| m_in_nib | input | 4 | Nibble to transmit, sampled on tick edges |
| m_in_frm | input | 1 | High while m_in_nib carries frame data |
| m_out_nib | output | 4 | Received nibble, updated on tick edges |
| m_out_frm | output | 1 | High while m_out_nib carries frame data |
| m_drop_flag | output | 1 | Sticky flag: a transmit frame was cut on a full FIFO |
| r_clk | input | 1 | RMII-side clock |
| r_rst | input | 1 | RMII-side synchronous reset, active high |
| r_out_pair | output | 2 | Transmitted dibit |
| r_out_frm | output | 1 | High while r_out_pair carries frame data |
| r_in_pair | input | 2 | Received dibit |
| r_in_frm | input | 1 | High while r_in_pair carries frame data |
| r_drop_flag | output | 1 | Sticky flag: a receive frame was cut on a full FIFO |

## Verification
The bench uses the default values AW=4, for a 16-entry FIFO with a start threshold of 8, and GAP_NIB=24. With these values, a 24-slot gap is longer than the FIFO can buffer. A second frame that follows the first almost at once therefore fills the FIFO while the pacer waits in P_GAP, so the overflow and drop path can be reached from ordinary traffic. The two clocks run at slightly different rates, so the fill level moves during a frame. Back-to-back frames with a short input gap test the minimum gap enforced in P_GAP.

// File: rtl/nibx_pkg.sv
package nibx_pkg;

    // One FIFO slot: frame flag plus nibble; frm=0 marks the end of a frame.
    typedef struct packed {
        logic       frm;
        logic [3:0] nib;
    } slot_t;

    typedef enum logic [1:0] {W_IDLE, W_FRAME, W_DROP, W_CLOSE} wr_state_t;

    typedef enum logic [1:0] {P_WAIT, P_SEND, P_GAP} pace_state_t;

endpackage

// File: rtl/nibx_afifo.sv
module nibx_afifo #(
    parameter int AW = 4,
    parameter int W  = 5
) (
    input  logic          wclk,
    input  logic          wrst,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    output logic          wfull,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          rd,
    output logic [W-1:0]  rdata,
    output logic          rempty,
    output logic [AW:0]   rlevel
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wbin, wgray, rbin, rgray;
    logic [AW:0]  rg_w1, rg_w2, wg_r1, wg_r2;
    logic [AW:0]  wbin_nx, rbin_nx;

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    assign wbin_nx = wbin + 1'b1;
    assign rbin_nx = rbin + 1'b1;

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    always_ff @(posedge wclk) begin
        if (wr) mem[wbin[AW-1:0]] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (rd) begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    // two-flop synchronizers for the Gray pointers
    always_ff @(posedge wclk) begin
        if (wrst) begin
            rg_w1 <= '0;
            rg_w2 <= '0;
        end else begin
            rg_w1 <= rgray;
            rg_w2 <= rg_w1;
        end
    end

    always_ff @(posedge rclk) begin
        if (rrst) begin
            wg_r1 <= '0;
            wg_r2 <= '0;
        end else begin
            wg_r1 <= wgray;
            wg_r2 <= wg_r1;
        end
    end

    assign wfull  = (wgray == {~rg_w2[AW:AW-1], rg_w2[AW-2:0]});
    assign rempty = (rgray == wg_r2);
    assign rlevel = g2b(wg_r2) - rbin;
    assign rdata  = mem[rbin[AW-1:0]];

    // R7: the writer never pushes into a full FIFO
    a_r7_no_push_full: assert property (@(posedge wclk) disable iff (wrst)
        !(wr && wfull));

    // R7: the pacer never pops an empty FIFO
    a_r7_no_pop_empty: assert property (@(posedge rclk) disable iff (rrst)
        !(rd && rempty));

    // R7: the fill level seen by the reader never exceeds the depth
    a_r7_level_bound: assert property (@(posedge rclk) disable iff (rrst)
        rlevel <= (AW+1)'(DEPTH));

endmodule

// File: rtl/nibx_writer.sv
module nibx_writer
    import nibx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stb,
    input  logic       frm,
    input  logic [3:0] nib,
    input  logic       full,
    output logic       push,
    output slot_t      pdata,
    output logic       drop_flag
);
    wr_state_t st, nxt;

    always_ff @(posedge clk) begin
        if (rst) st <= W_IDLE;
        else     st <= nxt;
    end

    always_comb begin
        nxt   = st;
        push  = 1'b0;
        pdata = '{frm: frm, nib: nib};
        unique case (st)
            W_IDLE: begin
                if (stb && frm) begin
                    if (full) nxt = W_DROP;
                    else begin
                        push = 1'b1;
                        nxt  = W_FRAME;
                    end
                end
            end
            W_FRAME: begin
                if (stb) begin
                    if (frm) begin
                        if (full) nxt = W_DROP;
                        else      push = 1'b1;
                    end else if (full) begin
                        nxt = W_CLOSE;
                    end else begin
                        push = 1'b1;
                        nxt  = W_IDLE;
                    end
                end
            end
            W_DROP: begin
                if (stb && !frm) nxt = W_CLOSE;
            end
            W_CLOSE: begin
                pdata.frm = 1'b0;
                if (!full) begin
                    push = 1'b1;
                    nxt  = W_IDLE;
                end
            end
            default: nxt = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                drop_flag <= 1'b0;
        else if (nxt == W_DROP) drop_flag <= 1'b1;
    end

    // R8: the drop flag is sticky until reset
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        $past(drop_flag) |-> drop_flag);

endmodule

// File: rtl/nibx_pacer.sv
module nibx_pacer
    import nibx_pkg::*;
#(
    parameter int AW      = 4,
    parameter int GAP_NIB = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    input  logic        empty,
    input  logic [AW:0] level,
    input  slot_t       head,
    output logic        pop,
    output logic        out_frm,
    output logic [3:0]  out_nib
);
    localparam int THR = (1 << AW) / 2;
    localparam int CW  = $clog2(GAP_NIB + 1);

    pace_state_t     st, nxt;
    logic [CW-1:0]   cnt;

    always_ff @(posedge clk) begin
        if (rst) st <= P_WAIT;
        else     st <= nxt;
    end

    always_comb begin
        nxt = st;
        pop = 1'b0;
        unique case (st)
            P_WAIT: begin
                if (step && level >= (AW+1)'(THR)) begin
                    pop = 1'b1;
                    nxt = head.frm ? P_SEND : P_GAP;
                end
            end
            P_SEND: begin
                if (step && !empty) begin
                    pop = 1'b1;
                    if (!head.frm) nxt = P_GAP;
                end
            end
            P_GAP: begin
                if (step && cnt >= CW'(GAP_NIB - 1)) nxt = P_WAIT;
            end
            default: nxt = P_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_frm <= 1'b0;
            out_nib <= '0;
            cnt     <= '0;
        end else if (step) begin
            if (pop && head.frm) begin
                out_frm <= 1'b1;
                out_nib <= head.nib;
            end else begin
                out_frm <= 1'b0;
            end
            if (st == P_GAP) cnt <= cnt + 1'b1;
            else             cnt <= CW'(1);
        end
    end

    // checker: idle slots seen on the output since the last frame slot
    logic [CW-1:0] idle_run;
    always_ff @(posedge clk) begin
        if (rst) idle_run <= CW'(GAP_NIB);
        else if (step) begin
            if (out_frm)                          idle_run <= '0;
            else if (idle_run != CW'(GAP_NIB))    idle_run <= idle_run + 1'b1;
        end
    end

    // R6: a new frame follows at least GAP_NIB idle slots
    a_r6_min_gap: assert property (@(posedge clk) disable iff (rst)
        ($rose(out_frm) && $past(st) == P_WAIT) |-> idle_run == CW'(GAP_NIB));

    // R5: a new frame starts only from a half-full FIFO
    a_r5_start_level: assert property (@(posedge clk) disable iff (rst)
        ($rose(out_frm) && $past(st) == P_WAIT) |-> $past(level) >= (AW+1)'(THR));

endmodule

// File: rtl/nib_pair_bridge.sv
module nib_pair_bridge
    import nibx_pkg::*;
#(
    parameter int AW      = 4,
    parameter int GAP_NIB = 24
) (
    input  logic       m_clk,
    input  logic       m_rst,
    input  logic       m_tick,
    input  logic [3:0] m_in_nib,
    input  logic       m_in_frm,
    output logic [3:0] m_out_nib,
    output logic       m_out_frm,
    output logic       m_drop_flag,
    input  logic       r_clk,
    input  logic       r_rst,
    output logic [1:0] r_out_pair,
    output logic       r_out_frm,
    input  logic [1:0] r_in_pair,
    input  logic       r_in_frm,
    output logic       r_drop_flag
);
    localparam int SW = $bits(slot_t);

    // ---------------- transmit: MII -> RMII ----------------
    logic        tx_push, tx_full, tx_pop, tx_empty;
    logic [AW:0] tx_lvl;
    slot_t       tx_wdat, tx_head;
    logic        tx_frm;
    logic [3:0]  tx_nib;
    logic        r_ph;

    nibx_writer u_txwr (
        .clk(m_clk), .rst(m_rst), .stb(m_tick), .frm(m_in_frm), .nib(m_in_nib),
        .full(tx_full), .push(tx_push), .pdata(tx_wdat), .drop_flag(m_drop_flag)
    );

    nibx_afifo #(.AW(AW), .W(SW)) u_txfifo (
        .wclk(m_clk), .wrst(m_rst), .wr(tx_push), .wdata(tx_wdat), .wfull(tx_full),
        .rclk(r_clk), .rrst(r_rst), .rd(tx_pop), .rdata(tx_head), .rempty(tx_empty),
        .rlevel(tx_lvl)
    );

    always_ff @(posedge r_clk) begin
        if (r_rst) r_ph <= 1'b0;
        else       r_ph <= ~r_ph;
    end

    nibx_pacer #(.AW(AW), .GAP_NIB(GAP_NIB)) u_txpace (
        .clk(r_clk), .rst(r_rst), .step(~r_ph), .empty(tx_empty), .level(tx_lvl),
        .head(tx_head), .pop(tx_pop), .out_frm(tx_frm), .out_nib(tx_nib)
    );

    // low dibit in the clock after the nibble loads, high dibit next
    assign r_out_pair = r_ph ? tx_nib[1:0] : tx_nib[3:2];
    assign r_out_frm  = tx_frm;

    // ---------------- receive: RMII -> MII ----------------
    logic        pk_ph;
    logic [1:0]  pk_lo;
    logic        pk_stb;
    logic        rx_push, rx_full, rx_pop, rx_empty;
    logic [AW:0] rx_lvl;
    slot_t       rx_wdat, rx_head;

    always_ff @(posedge r_clk) begin
        if (r_rst) begin
            pk_ph <= 1'b0;
            pk_lo <= '0;
        end else if (r_in_frm) begin
            pk_ph <= ~pk_ph;
            if (!pk_ph) pk_lo <= r_in_pair;
        end else begin
            pk_ph <= 1'b0;
        end
    end

    assign pk_stb = !r_in_frm || pk_ph;

    nibx_writer u_rxwr (
        .clk(r_clk), .rst(r_rst), .stb(pk_stb), .frm(r_in_frm), .nib({r_in_pair, pk_lo}),
        .full(rx_full), .push(rx_push), .pdata(rx_wdat), .drop_flag(r_drop_flag)
    );

    nibx_afifo #(.AW(AW), .W(SW)) u_rxfifo (
        .wclk(r_clk), .wrst(r_rst), .wr(rx_push), .wdata(rx_wdat), .wfull(rx_full),
        .rclk(m_clk), .rrst(m_rst), .rd(rx_pop), .rdata(rx_head), .rempty(rx_empty),
        .rlevel(rx_lvl)
    );

    nibx_pacer #(.AW(AW), .GAP_NIB(GAP_NIB)) u_rxpace (
        .clk(m_clk), .rst(m_rst), .step(m_tick), .empty(rx_empty), .level(rx_lvl),
        .head(rx_head), .pop(rx_pop), .out_frm(m_out_frm), .out_nib(m_out_nib)
    );

    // R3: the MII output moves only on tick edges
    a_r3_tick_only: assert property (@(posedge m_clk) disable iff (m_rst)
        !$past(m_tick) |-> ($stable(m_out_frm) && $stable(m_out_nib)));

endmodule

// File: tb/nib_pair_bridge_bench.sv
`timescale 1ns/1ps
module nib_pair_bridge_bench;
    localparam int AW = 4, GAP_NIB = 24, THR = 8;

    logic m_clk = 0, r_clk = 0, m_rst = 1, r_rst = 1, m_tick = 0;
    logic [3:0] m_in_nib = 0, m_out_nib;
    logic m_in_frm = 0, m_out_frm, m_drop_flag;
    logic [1:0] r_out_pair, r_in_pair = 0;
    logic r_out_frm, r_in_frm = 0, r_drop_flag;

    nib_pair_bridge #(.AW(AW), .GAP_NIB(GAP_NIB)) u_nib_pair_bridge (
        .m_clk(m_clk), .m_rst(m_rst), .m_tick(m_tick), .m_in_nib(m_in_nib),
        .m_in_frm(m_in_frm), .m_out_nib(m_out_nib), .m_out_frm(m_out_frm),
        .m_drop_flag(m_drop_flag), .r_clk(r_clk), .r_rst(r_rst),
        .r_out_pair(r_out_pair), .r_out_frm(r_out_frm), .r_in_pair(r_in_pair),
        .r_in_frm(r_in_frm), .r_drop_flag(r_drop_flag)
    );

    always #5    m_clk = ~m_clk;
    always #12.4 r_clk = ~r_clk;

    int n_chk = 0, n_fail = 0;
    int m_fr_wr = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---- RMII output monitor ----
    logic [3:0] tcap [0:255];
    int tcap_n = 0, tfr_n = 0, tidle = 0, tgap_min = 9999, t_first_wr = -1;
    int tstart [0:15];
    int tlen [0:15];
    bit tph = 0, tprev = 0, t_odd = 0;
    logic [1:0] tlo = 0;

    always @(negedge r_clk) begin
        if (r_out_frm) begin
            if (!tprev) begin
                if (tfr_n > 0 && tidle < tgap_min) tgap_min = tidle;
                if (tfr_n == 0) t_first_wr = m_fr_wr;
                if (tfr_n < 16) tstart[tfr_n] = tcap_n;
                tph = 0;
            end
            if (!tph) tlo = r_out_pair;
            else if (tcap_n < 256) begin
                tcap[tcap_n] = {r_out_pair, tlo};
                tcap_n++;
            end
            tph = !tph;
            tidle = 0;
        end else begin
            if (tprev) begin
                if (tph) t_odd = 1;
                if (tfr_n < 16) tlen[tfr_n] = tcap_n - tstart[tfr_n];
                tfr_n++;
            end
            tidle++;
        end
        tprev = r_out_frm;
    end

    // ---- MII output monitor and tick generator ----
    logic [3:0] mcap [0:255];
    int mcap_n = 0, mfr_n = 0, midle = 0, mgap_min = 9999, m_stab_err = 0, tk = 0;
    int mstart [0:15];
    int mlen [0:15];
    bit mprev = 0;
    logic [4:0] mlast = 0;

    always @(negedge m_clk) begin
        if (m_tick) begin
            if (m_out_frm) begin
                if (!mprev) begin
                    if (mfr_n > 0 && midle < mgap_min) mgap_min = midle;
                    if (mfr_n < 16) mstart[mfr_n] = mcap_n;
                end
                if (mcap_n < 256) begin
                    mcap[mcap_n] = m_out_nib;
                    mcap_n++;
                end
                midle = 0;
            end else begin
                if (mprev) begin
                    if (mfr_n < 16) mlen[mfr_n] = mcap_n - mstart[mfr_n];
                    mfr_n++;
                end
                midle++;
            end
            mprev = m_out_frm;
        end else if ({m_out_frm, m_out_nib} != mlast) begin
            m_stab_err++;
        end
        mlast = {m_out_frm, m_out_nib};
        tk = (tk == 4) ? 0 : tk + 1;
        m_tick = (tk == 4);
    end

    task automatic clr_caps();
        tcap_n = 0; tfr_n = 0; tgap_min = 9999; t_first_wr = -1; t_odd = 0;
        mcap_n = 0; mfr_n = 0; mgap_min = 9999; m_stab_err = 0;
    endtask

    task automatic mii_frame(input int n, input int seed, input int idle_after);
        for (int i = 0; i < n; i++) begin
            @(posedge m_clk iff m_tick); #1;
            m_in_frm = 1; m_in_nib = 4'(seed + i * 5); m_fr_wr = i;
        end
        @(posedge m_clk iff m_tick); #1;
        m_in_frm = 0; m_in_nib = 0; m_fr_wr = n;
        for (int i = 0; i < idle_after; i++) @(posedge m_clk iff m_tick);
    endtask

    task automatic rmii_frame(input int n, input int seed, input int idle_after);
        for (int i = 0; i < n; i++) begin
            logic [3:0] v;
            v = 4'(seed + i * 5);
            @(posedge r_clk); #1; r_in_frm = 1; r_in_pair = v[1:0];
            @(posedge r_clk); #1; r_in_pair = v[3:2];
        end
        @(posedge r_clk); #1; r_in_frm = 0; r_in_pair = 0;
        for (int i = 0; i < 2 * idle_after; i++) @(posedge r_clk);
    endtask

    task automatic settle();
        for (int i = 0; i < 500; i++) @(posedge r_clk);
    endtask

    // compare frame fr of a capture against the generated pattern
    task automatic chk_tx(input int fr, input int n, input int seed, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++)
            if (tcap[tstart[fr] + i] !== 4'(seed + i * 5)) bad++;
        check(bad == 0, req, bad, 0);
    endtask

    task automatic chk_rx(input int fr, input int n, input int seed, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++)
            if (mcap[mstart[fr] + i] !== 4'(seed + i * 5)) bad++;
        check(bad == 0, req, bad, 0);
    endtask

    task automatic t_reset();   // R1
        check(m_out_frm === 0 && r_out_frm === 0, "R1 frame outputs low", {m_out_frm, r_out_frm}, 0);
        check(m_out_nib === 0 && r_out_pair === 0, "R1 data outputs zero", {m_out_nib, r_out_pair}, 0);
        check(m_drop_flag === 0 && r_drop_flag === 0, "R1 drop flags clear", {m_drop_flag, r_drop_flag}, 0);
    endtask

    task automatic t_tx_single();   // R2 R4 R5
        clr_caps();
        mii_frame(20, 3, 4);
        settle();
        check(tfr_n == 1, "R4 tx one frame", tfr_n, 1);
        check(tlen[0] == 20, "R4 tx length", tlen[0], 20);
        chk_tx(0, 20, 3, "R2 tx dibit order low first / R7 content");
        check(t_odd == 0, "R2 tx even dibit count", t_odd, 0);
        check(t_first_wr >= THR, "R5 tx start threshold", t_first_wr, THR);
    endtask

    task automatic t_tx_b2b();   // R6 R4
        clr_caps();
        mii_frame(16, 1, 14);
        mii_frame(16, 7, 4);
        settle();
        check(tfr_n == 2, "R4 tx two frames", tfr_n, 2);
        chk_tx(0, 16, 1, "R4 tx frame A");
        chk_tx(1, 16, 7, "R4 tx frame B");
        check(tgap_min >= 2 * GAP_NIB, "R6 tx min gap", tgap_min, 2 * GAP_NIB);
    endtask

    task automatic t_rx();   // R3 R4 R6
        clr_caps();
        rmii_frame(18, 2, 14);
        rmii_frame(16, 9, 4);
        settle();
        check(mfr_n == 2, "R4 rx two frames", mfr_n, 2);
        check(mlen[0] == 18, "R4 rx length", mlen[0], 18);
        chk_rx(0, 18, 2, "R3 rx dibit pairing");
        chk_rx(1, 16, 9, "R3 rx frame B");
        check(m_stab_err == 0, "R3 rx output changes only on tick", m_stab_err, 0);
        check(mgap_min >= GAP_NIB, "R6 rx min gap", mgap_min, GAP_NIB);
    endtask

    task automatic t_overflow();   // R8
        int bad;
        clr_caps();
        mii_frame(12, 4, 1);
        mii_frame(40, 11, 30);
        settle();
        check(m_drop_flag === 1, "R8 drop flag set", m_drop_flag, 1);
        mii_frame(12, 6, 4);
        settle();
        check(tfr_n == 3, "R8 frame count", tfr_n, 3);
        chk_tx(0, 12, 4, "R8 frame before overflow intact");
        check(tlen[1] > 0 && tlen[1] < 40, "R8 cut frame shortened", tlen[1], 16);
        bad = 0;
        for (int i = 0; i < tlen[1]; i++)
            if (tcap[tstart[1] + i] !== 4'(11 + i * 5)) bad++;
        check(bad == 0, "R8 cut frame is a leading part", bad, 0);
        check(tlen[2] == 12, "R8 next frame length", tlen[2], 12);
        chk_tx(2, 12, 6, "R8 next frame intact");
        check(m_drop_flag === 1, "R8 drop flag sticky", m_drop_flag, 1);
        check(r_drop_flag === 0, "R8 rx flag untouched", r_drop_flag, 0);
    endtask

    initial begin
        for (int i = 0; i < 10; i++) @(negedge m_clk);
        m_rst = 0;
        @(negedge r_clk); r_rst = 0;
        for (int i = 0; i < 10; i++) @(negedge r_clk);
        t_reset();
        t_tx_single();
        t_tx_b2b();
        t_rx();
        t_overflow();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule